// File: doc/BRIEF.md
# Recoverable NMI Trap-State Shadow

This block sits beside the machine-mode CSR file of a small RISC-V style core and makes non-maskable interrupts recoverable. A non-maskable interrupt can arrive while an ordinary trap handler is still running. When it does, the NMI trap entry would overwrite the return address, the cause and the saved privilege and interrupt-enable bits that the interrupted handler still needs. To prevent that, the block keeps a one-deep shadow copy of this state. The copy is taken in the cycle the request is accepted, before the trap entry logic writes any CSR.

The block reports acceptance to the trap entry logic on `nmi_take_o`, which means the NMI trap is taken at the next instruction step, and it raises its NMI-mode flag. The NMI handler ends with an MRET. If that MRET retires cleanly while the flag is set, the block drives write enables and data to the CSR file for three registers: mstatus, where only the previous-privilege field and the previous-interrupt-enable bit are replaced, mepc and mcause. The CSR file must give these writes precedence over its own MRET side effects in the same cycle. The interrupted handler then resumes with its trap state intact. The flag clears on the following clock edge.

Top module: `nmi_shadow_stack`

## Requirements
- R1: After reset, `nmi_mode_o`, `nmi_take_o` and all three restore write enables are low.
- R2: When `nmi_req_i` is high, `nmi_mode_o` is low and `debug_mode_i` is low, `nmi_take_o` is high in that same cycle and `nmi_mode_o` is high from the next clock edge.
- R3: While `debug_mode_i` is high, a request is ignored: `nmi_take_o` stays low and `nmi_mode_o` does not rise.
- R4: A request made while `nmi_mode_o` is high is ignored: `nmi_take_o` stays low and the snapshot keeps the values taken at the earlier acceptance.
- R5: On acceptance, the snapshot records mstatus bits [12:11] (previous privilege), mstatus bit 7 (previous interrupt enable), the full mepc and the full mcause, using the input values present in the acceptance cycle.
- R6: When `mret_retire_i` is high, `sync_trap_i` is low and `nmi_mode_o` is high, the three restore write enables are high together in that cycle, and `nmi_mode_o` is low from the next edge.
- R7: The mstatus restore data equals `mstatus_i` of the exit cycle with bits [12:11] and bit 7 replaced by the saved values. Every other bit is unchanged.
- R8: The mepc and mcause restore data equal the saved mepc and mcause.
- R9: An MRET that retires with `sync_trap_i` high asserts no restore enable and leaves `nmi_mode_o` high.
- R10: An MRET that retires while `nmi_mode_o` is low asserts no restore enable.
- R11: Once NMI mode has been left, a new request is accepted again and overwrites the snapshot with the then-current values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nmi_req_i | input | 1 | Non-maskable interrupt request |
| debug_mode_i | input | 1 | Core is in debug mode |
| mstatus_i | input | 32 | Current mstatus value |
| mepc_i | input | 32 | Current mepc value |
| mcause_i | input | 32 | Current mcause value |
| mret_retire_i | input | 1 | An MRET retires this cycle |
| sync_trap_i | input | 1 | The retiring instruction raised a synchronous trap |
| nmi_take_o | output | 1 | Request accepted; take NMI trap at next step |
| nmi_mode_o | output | 1 | NMI handler is active |
| mstatus_we_o | output | 1 | Restore write enable for mstatus |
| mstatus_wdata_o | output | 32 | Restore data for mstatus |
| mepc_we_o | output | 1 | Restore write enable for mepc |
| mepc_wdata_o | output | 32 | Restore data for mepc |
| mcause_we_o | output | 1 | Restore write enable for mcause |
| mcause_wdata_o | output | 32 | Restore data for mcause |

## Verification
The collision of interest is an NMI exit and a fresh NMI request in the same cycle. The bench provokes it by holding `nmi_req_i` high across the clean MRET that ends a handler. In that cycle the bench judges that `nmi_take_o` stays low and that the restore carries the old snapshot. On the next cycle, with the flag now clear, the still-pending request must be accepted and must capture the new CSR values, which a second exit then reveals. A second same-cycle case pairs the MRET with a synchronous trap, and the bench confirms that no restore occurs and that NMI mode persists. The nested scenario starts an exception handler, brings in an NMI, and compares mepc, mcause and the privilege field after the NMI handler's MRET.

// File: rtl/nmi_shadow_pkg.sv
package nmi_shadow_pkg;
   // Default geometry of the machine status word
   localparam int unsigned DEF_XLEN     = 32;
   localparam int unsigned DEF_MPP_W    = 2;
   localparam int unsigned DEF_MPP_LSB  = 11;
   localparam int unsigned DEF_MPIE_BIT = 7;

   typedef enum logic {
      NMI_IDLE   = 1'b0,
      NMI_ACTIVE = 1'b1
   } nmi_state_e;
endpackage

// File: rtl/nmi_gate.sv
module nmi_gate
   import nmi_shadow_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic nmi_req_i,
   input  logic debug_mode_i,
   input  logic mret_retire_i,
   input  logic sync_trap_i,
   output logic accept_o,
   output logic leave_o,
   output logic mode_o
);
   nmi_state_e state_q, state_d;

   assign accept_o = nmi_req_i && (state_q == NMI_IDLE) && !debug_mode_i;
   assign leave_o  = mret_retire_i && (state_q == NMI_ACTIVE) && !sync_trap_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         NMI_IDLE:   if (accept_o) state_d = NMI_ACTIVE;
         NMI_ACTIVE: if (leave_o)  state_d = NMI_IDLE;
         default:    state_d = NMI_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= NMI_IDLE;
      else         state_q <= state_d;
   end

   assign mode_o = (state_q == NMI_ACTIVE);

   p_accept_sets_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept_o |=> mode_o);
   p_debug_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (debug_mode_i && !mode_o) |=> !mode_o);
   p_leave_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      leave_o |=> !mode_o);
   p_trap_holds_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o && sync_trap_i) |=> mode_o);
endmodule

// File: rtl/nmi_snapshot.sv
module nmi_snapshot #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned MPP_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             capture_i,
   input  logic [MPP_W-1:0] mpp_i,
   input  logic             mpie_i,
   input  logic [XLEN-1:0]  epc_i,
   input  logic [XLEN-1:0]  cause_i,
   output logic [MPP_W-1:0] mpp_o,
   output logic             mpie_o,
   output logic [XLEN-1:0]  epc_o,
   output logic [XLEN-1:0]  cause_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mpp_o   <= '0;
         mpie_o  <= 1'b0;
         epc_o   <= '0;
         cause_o <= '0;
      end else if (capture_i) begin
         mpp_o   <= mpp_i;
         mpie_o  <= mpie_i;
         epc_o   <= epc_i;
         cause_o <= cause_i;
      end
   end

   p_snapshot_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !capture_i |=> ($stable(epc_o) && $stable(cause_o) && $stable(mpp_o) && $stable(mpie_o)));
   p_snapshot_taken_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      capture_i |=> (epc_o == $past(epc_i) && cause_o == $past(cause_i)));
endmodule

// File: rtl/nmi_restore.sv
module nmi_restore #(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned MPP_W    = 2,
   parameter int unsigned MPP_LSB  = 11,
   parameter int unsigned MPIE_BIT = 7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             leave_i,
   input  logic [XLEN-1:0]  mstatus_i,
   input  logic [MPP_W-1:0] sv_mpp_i,
   input  logic             sv_mpie_i,
   input  logic [XLEN-1:0]  sv_epc_i,
   input  logic [XLEN-1:0]  sv_cause_i,
   output logic             mstatus_we_o,
   output logic [XLEN-1:0]  mstatus_wdata_o,
   output logic             mepc_we_o,
   output logic [XLEN-1:0]  mepc_wdata_o,
   output logic             mcause_we_o,
   output logic [XLEN-1:0]  mcause_wdata_o
);
   // Bit-wise merge: each status bit picks saved field or live value
   for (genvar i = 0; i < XLEN; i++) begin : g_bit
      if (i >= MPP_LSB && i < MPP_LSB + MPP_W) begin : g_mpp
         assign mstatus_wdata_o[i] = sv_mpp_i[i-MPP_LSB];
      end else if (i == MPIE_BIT) begin : g_mpie
         assign mstatus_wdata_o[i] = sv_mpie_i;
      end else begin : g_keep
         assign mstatus_wdata_o[i] = mstatus_i[i];
      end
   end

   assign mstatus_we_o   = leave_i;
   assign mepc_we_o      = leave_i;
   assign mcause_we_o    = leave_i;
   assign mepc_wdata_o   = sv_epc_i;
   assign mcause_wdata_o = sv_cause_i;

   p_mstatus_fields_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mstatus_we_o |-> (mstatus_wdata_o[MPP_LSB +: MPP_W] == sv_mpp_i
                        && mstatus_wdata_o[MPIE_BIT] == sv_mpie_i));
endmodule

// File: rtl/nmi_shadow_stack.sv
module nmi_shadow_stack
   import nmi_shadow_pkg::*;
#(
   parameter int unsigned XLEN     = DEF_XLEN,
   parameter int unsigned MPP_W    = DEF_MPP_W,
   parameter int unsigned MPP_LSB  = DEF_MPP_LSB,
   parameter int unsigned MPIE_BIT = DEF_MPIE_BIT
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            nmi_req_i,
   input  logic            debug_mode_i,
   input  logic [XLEN-1:0] mstatus_i,
   input  logic [XLEN-1:0] mepc_i,
   input  logic [XLEN-1:0] mcause_i,
   input  logic            mret_retire_i,
   input  logic            sync_trap_i,
   output logic            nmi_take_o,
   output logic            nmi_mode_o,
   output logic            mstatus_we_o,
   output logic [XLEN-1:0] mstatus_wdata_o,
   output logic            mepc_we_o,
   output logic [XLEN-1:0] mepc_wdata_o,
   output logic            mcause_we_o,
   output logic [XLEN-1:0] mcause_wdata_o
);
   localparam int unsigned MPP_MSB = MPP_LSB + MPP_W - 1;

   if (MPP_W == 0 || MPP_MSB >= XLEN) begin : g_bad_mpp
      $error("previous-privilege field does not fit the status word");
   end
   if (MPIE_BIT >= XLEN || (MPIE_BIT >= MPP_LSB && MPIE_BIT <= MPP_MSB)) begin : g_bad_mpie
      $error("previous-interrupt-enable bit misplaced");
   end

   logic             accept, leave;
   logic [MPP_W-1:0] sv_mpp;
   logic             sv_mpie;
   logic [XLEN-1:0]  sv_epc, sv_cause;

   nmi_gate u_gate (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .nmi_req_i     (nmi_req_i),
      .debug_mode_i  (debug_mode_i),
      .mret_retire_i (mret_retire_i),
      .sync_trap_i   (sync_trap_i),
      .accept_o      (accept),
      .leave_o       (leave),
      .mode_o        (nmi_mode_o)
   );

   nmi_snapshot #(.XLEN(XLEN), .MPP_W(MPP_W)) u_snap (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .capture_i (accept),
      .mpp_i     (mstatus_i[MPP_MSB:MPP_LSB]),
      .mpie_i    (mstatus_i[MPIE_BIT]),
      .epc_i     (mepc_i),
      .cause_i   (mcause_i),
      .mpp_o     (sv_mpp),
      .mpie_o    (sv_mpie),
      .epc_o     (sv_epc),
      .cause_o   (sv_cause)
   );

   nmi_restore #(.XLEN(XLEN), .MPP_W(MPP_W), .MPP_LSB(MPP_LSB), .MPIE_BIT(MPIE_BIT)) u_rest (
      .clk_i           (clk_i),
      .rst_ni          (rst_ni),
      .leave_i         (leave),
      .mstatus_i       (mstatus_i),
      .sv_mpp_i        (sv_mpp),
      .sv_mpie_i       (sv_mpie),
      .sv_epc_i        (sv_epc),
      .sv_cause_i      (sv_cause),
      .mstatus_we_o    (mstatus_we_o),
      .mstatus_wdata_o (mstatus_wdata_o),
      .mepc_we_o       (mepc_we_o),
      .mepc_wdata_o    (mepc_wdata_o),
      .mcause_we_o     (mcause_we_o),
      .mcause_wdata_o  (mcause_wdata_o)
   );

   assign nmi_take_o = accept;

   p_no_take_in_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_mode_o |-> !nmi_take_o);
   p_no_take_in_debug_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      debug_mode_i |-> !nmi_take_o);
   p_we_together_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mstatus_we_o == mepc_we_o) && (mepc_we_o == mcause_we_o));
   p_we_needs_mode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mepc_we_o |-> nmi_mode_o);
   p_trap_blocks_restore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_trap_i |-> !mstatus_we_o);
endmodule

// File: tb/sim_nmi_shadow_stack.sv
`timescale 1ns/1ps
module sim_nmi_shadow_stack;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, dbg = 1'b0, mret = 1'b0, strap = 1'b0;
   logic [31:0] mstatus = '0, mepc = '0, mcause = '0;
   logic        take, mode, ms_we, epc_we, cause_we;
   logic [31:0] ms_wd, epc_wd, cause_wd;
   int          checks = 0, fails = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   nmi_shadow_stack u0 (
      .clk_i(clk), .rst_ni(rst_n), .nmi_req_i(req), .debug_mode_i(dbg),
      .mstatus_i(mstatus), .mepc_i(mepc), .mcause_i(mcause),
      .mret_retire_i(mret), .sync_trap_i(strap),
      .nmi_take_o(take), .nmi_mode_o(mode),
      .mstatus_we_o(ms_we), .mstatus_wdata_o(ms_wd),
      .mepc_we_o(epc_we), .mepc_wdata_o(epc_wd),
      .mcause_we_o(cause_we), .mcause_wdata_o(cause_wd)
   );

   task automatic chk(input string req_tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req_tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] merge(input logic [31:0] ms, input logic [1:0] pp, input logic pie);
      merge = (ms & ~32'h0000_1880) | ({30'd0, pp} << 11) | ({31'd0, pie} << 7);
   endfunction

   function automatic logic [31:0] mk_status(input logic [1:0] pp, input logic pie, input logic [31:0] rest);
      mk_status = merge(rest, pp, pie);
   endfunction

   // drive on falling edge, settle, then evaluate
   task automatic step();
      @(posedge clk); @(negedge clk); #1;
   endtask

   task automatic idle_inputs();
      req = 0; dbg = 0; mret = 0; strap = 0;
   endtask

   // accept an NMI with given state; checks R2
   task automatic enter(input logic [31:0] ms, input logic [31:0] ep, input logic [31:0] ca);
      mstatus = ms; mepc = ep; mcause = ca; req = 1; #1;
      chk("R2", "take on accept", {31'd0, take}, 32'd1);
      step();
      req = 0; #1;
      chk("R2", "mode after accept", {31'd0, mode}, 32'd1);
   endtask

   // clean MRET exit; checks R6/R7/R8
   task automatic leave(input logic [31:0] ms_now, input logic [1:0] pp, input logic pie,
                        input logic [31:0] ep, input logic [31:0] ca);
      mstatus = ms_now; mret = 1; #1;
      chk("R6", "restore enables", {29'd0, ms_we, epc_we, cause_we}, 32'd7);
      chk("R7", "mstatus data", ms_wd, merge(ms_now, pp, pie));
      chk("R8", "mepc data", epc_wd, ep);
      chk("R8", "mcause data", cause_wd, ca);
      step();
      mret = 0; #1;
      chk("R6", "mode after exit", {31'd0, mode}, 32'd0);
   endtask

   task automatic t_reset();
      #1;
      chk("R1", "reset outputs", {27'd0, take, mode, ms_we, epc_we, cause_we}, 32'd0);
   endtask

   task automatic t_nested();
      // exception handler running: mepc/mcause/MPP from the exception
      logic [31:0] ms0 = mk_status(2'b11, 1'b1, 32'h0000_0008);
      enter(ms0, 32'h0000_0100, 32'h0000_0002);
      // NMI trap entry overwrites state
      mepc = 32'h0000_0480; mcause = 32'h8000_001F;
      leave(mk_status(2'b00, 1'b0, 32'h0004_0008), 2'b11, 1'b1, 32'h0000_0100, 32'h0000_0002);
      chk("R5", "nested MPP restored", {30'd0, ms_wd[12:11]}, 32'd3);
   endtask

   task automatic t_debug();
      dbg = 1; req = 1; #1;
      chk("R3", "no take in debug", {31'd0, take}, 32'd0);
      step();
      chk("R3", "mode stays low", {31'd0, mode}, 32'd0);
      idle_inputs();
   endtask

   task automatic t_repeat();
      enter(mk_status(2'b01, 1'b0, 32'h0), 32'hAAAA_0000, 32'h0000_000B);
      mstatus = mk_status(2'b10, 1'b1, 32'h0); mepc = 32'h5555_0000; mcause = 32'h7; req = 1; #1;
      chk("R4", "no take in mode", {31'd0, take}, 32'd0);
      step();
      req = 0;
      leave(32'hFFFF_FFFF, 2'b01, 1'b0, 32'hAAAA_0000, 32'h0000_000B);
   endtask

   task automatic t_sync_trap();
      enter(mk_status(2'b10, 1'b0, 32'h0), 32'h0000_2000, 32'h0000_0005);
      mret = 1; strap = 1; #1;
      chk("R9", "no restore on trap", {29'd0, ms_we, epc_we, cause_we}, 32'd0);
      step();
      mret = 0; strap = 0; #1;
      chk("R9", "mode kept", {31'd0, mode}, 32'd1);
      leave(32'h0, 2'b10, 1'b0, 32'h0000_2000, 32'h0000_0005);
   endtask

   task automatic t_mret_idle();
      mret = 1; #1;
      chk("R10", "no restore when idle", {29'd0, ms_we, epc_we, cause_we}, 32'd0);
      step();
      mret = 0; #1;
      chk("R10", "mode low", {31'd0, mode}, 32'd0);
   endtask

   task automatic t_collide();
      enter(mk_status(2'b11, 1'b0, 32'h0), 32'h0000_3000, 32'h0000_0001);
      // exit and new request in the same cycle
      mstatus = mk_status(2'b00, 1'b1, 32'h0); mepc = 32'h0000_4000; mcause = 32'h8000_0003;
      req = 1; mret = 1; #1;
      chk("R4", "no take during exit", {31'd0, take}, 32'd0);
      chk("R8", "old snapshot on exit", epc_wd, 32'h0000_3000);
      step();
      mret = 0; #1;
      chk("R11", "pending request accepted", {31'd0, take}, 32'd1);
      step();
      req = 0; #1;
      chk("R11", "mode re-entered", {31'd0, mode}, 32'd1);
      leave(32'h0, 2'b00, 1'b1, 32'h0000_4000, 32'h8000_0003);
   endtask

   initial begin
      #1;
      t_reset();
      #20; @(negedge clk); rst_n = 1; #1;
      t_reset();
      t_nested();
      t_debug();
      t_repeat();
      t_sync_trap();
      t_mret_idle();
      t_collide();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule